// File: doc/BRIEF.md
# Indexed chipset configuration port

This block is the configuration register file of a PC chipset. The host reaches it over an 8-bit I/O bus with an address, a write strobe, a read strobe and separate write and read data. One port loads an index register. A second port then reads or writes the configuration register that the index selects, but only inside two sparse index windows. A third port gives gated access to one low register. Two standalone scratch bytes sit on ports of their own.

A few register bits leave the block as decoded side-band controls: the external cache enable and SMRAM visibility. A small power-management handshake raises a one-cycle SMI request and keeps a sticky forced-green flag. It also merges the CPU's live SMM state into a status register's read value. Memory shadow decoding is done elsewhere, so the block exports the four raw shadow-control bytes unchanged.

Top module: `cfg_index_port`

## Requirements
- R1: A write to port 0x0022 loads the 8-bit index. A read of port 0x0022 returns 0xFF.
- R2: With the index in 0x20..0x2F or 0xE0..0xEF, port 0x0024 writes the selected register and reads it back.
- R3: With the index outside both windows, writes to port 0x0024 change no register and reads return 0xFF.
- R4: Port 0x0023 reads and writes register 0x01 only while the index is 0x01. Otherwise it reads 0xFF and writes are dropped.
- R5: Ports 0x00E1 and 0x00E2 are two independent scratch bytes, reset to 0xFF, accessed without the index.
- R6: After reset the registers hold: 0x01=C0, 0x22=C4, 0x25=7C, 0x26=10, 0x27=DE, 0x28=F8, 0x29=10, 0x2A=E0, 0x2B=10, 0x2D=C0, 0xE8=08, 0xE9=08, 0xEB=FF, 0xEF=40. All other registers hold 00.
- R7: `ext_cache_en` equals bit 4 of register 0x21. `smram_visible` equals bit 7 of register 0x24.
- R8: A data-port write of register 0xE1 with bit 3 set, while bit 0 of register 0xE0 is 1, makes `smi_req` high for exactly the one cycle after the write edge and sets the forced-green flag. With bit 0 of 0xE0 at 0 the same write raises nothing.
- R9: A data-port write of register 0xE0 with bit 0 clear clears the forced-green flag.
- R10: A read of register 0xE0 returns the stored byte with bit 3 replaced by NOT `in_smm` and bit 0 replaced by the forced-green flag.
- R11: `io_rdata` is loaded on the clock edge where `io_rd` is high and holds otherwise. It resets to 0xFF. Any unmapped port address reads 0xFF and a write to it has no effect.
- R12: `shadow_ctl_a`, `shadow_blk_en`, `shadow_ctl_b` and `shadow_ext` show the raw values of registers 0x22, 0x23, 0x26 and 0x2D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| in_smm | input | 1 | CPU is in system management mode |
| ext_cache_en | output | 1 | External cache enable |
| smram_visible | output | 1 | SMRAM visible to normal accesses |
| smi_req | output | 1 | One-cycle SMI request |
| shadow_ctl_a | output | 8 | Raw register 0x22 |
| shadow_blk_en | output | 8 | Raw register 0x23 |
| shadow_ctl_b | output | 8 | Raw register 0x26 |
| shadow_ext | output | 8 | Raw register 0x2D |

## Verification
The index and data ports are tried with indices inside the low window, inside the high window, just outside both, and on the gated low register. These cases separate window decoding from plain index storage and show whether a blocked access leaks into a real register. Reads of reset values at scattered indices catch a wrong per-slot reset table. The power-management handshake is driven with the arm bit both clear and set, and with `in_smm` both low and high. This tells the status merge apart from the stored byte and shows that the SMI pulse lasts a single cycle.

// File: rtl/cfg_port_pkg.sv
// Shared constants for the indexed configuration port.
// Assumes an I/O address of up to 16 bits and byte-wide registers.
package cfg_port_pkg;
    localparam int DATA_W = 8;
    localparam logic [15:0] PORT_INDEX = 16'h0022;
    localparam logic [15:0] PORT_LOWREG = 16'h0023;
    localparam logic [15:0] PORT_DATA  = 16'h0024;
    localparam logic [15:0] PORT_SCR0  = 16'h00E1;
    localparam logic [15:0] PORT_SCR1  = 16'h00E2;
    localparam logic [7:0]  LOWREG_IDX   = 8'h01;
    localparam logic [7:0]  LOWREG_RESET = 8'hC0;
    localparam logic [7:0]  SCR_RESET    = 8'hFF;
    localparam logic [7:0]  IDX_STATUS   = 8'hE0;
    localparam logic [7:0]  IDX_TRIGGER  = 8'hE1;

    // Reset value for a windowed register, by its full index.
    function automatic logic [7:0] win_reset(input logic [7:0] idx);
        case (idx)
            8'h22: win_reset = 8'hC4;
            8'h25: win_reset = 8'h7C;
            8'h26: win_reset = 8'h10;
            8'h27: win_reset = 8'hDE;
            8'h28: win_reset = 8'hF8;
            8'h29: win_reset = 8'h10;
            8'h2A: win_reset = 8'hE0;
            8'h2B: win_reset = 8'h10;
            8'h2D: win_reset = 8'hC0;
            8'hE8: win_reset = 8'h08;
            8'hE9: win_reset = 8'h08;
            8'hEB: win_reset = 8'hFF;
            8'hEF: win_reset = 8'h40;
            default: win_reset = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfg_port_decode.sv
// Address decoder: turns the port address and current index into
// one-hot access selects. Assumes a single access per cycle.
module cfg_port_decode
    import cfg_port_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [3:0] WIN_LO_HI = 4'h2,
    parameter logic [3:0] WIN_HI_HI = 4'hE
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        idx_q,
    output logic              sel_index,
    output logic              sel_lowreg,
    output logic              sel_data,
    output logic              sel_scr0,
    output logic              sel_scr1
);
    logic in_window;

    // Window check and per-port selects.
    always_comb begin
        in_window  = (idx_q[7:4] == WIN_LO_HI) || (idx_q[7:4] == WIN_HI_HI);
        sel_index  = (io_addr == ADDR_W'(PORT_INDEX));
        sel_lowreg = (io_addr == ADDR_W'(PORT_LOWREG)) && (idx_q == LOWREG_IDX);
        sel_data   = (io_addr == ADDR_W'(PORT_DATA)) && in_window;
        sel_scr0   = (io_addr == ADDR_W'(PORT_SCR0));
        sel_scr1   = (io_addr == ADDR_W'(PORT_SCR1));
    end
endmodule

// File: rtl/cfg_win_regs.sv
// Storage for the two 16-entry index windows. The slot is formed from
// index bit 7 (which window) and the low nibble. Assumes the caller
// qualifies the write enable with a valid window.
module cfg_win_regs
    import cfg_port_pkg::*;
#(
    parameter int WIN_DEPTH = 16,
    parameter logic [3:0] WIN_LO_HI = 4'h2,
    parameter logic [3:0] WIN_HI_HI = 4'hE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rd_val,
    output logic       cache_bit,
    output logic       smram_bit,
    output logic       arm_bit,
    output logic [7:0] reg_22,
    output logic [7:0] reg_23,
    output logic [7:0] reg_26,
    output logic [7:0] reg_2d
);
    localparam int LOW_W  = $clog2(WIN_DEPTH);
    localparam int SLOTS  = 2 * WIN_DEPTH;
    localparam int SLOT_W = LOW_W + 1;

    logic [7:0] slot_q [SLOTS];
    logic [SLOT_W-1:0] sel_slot;

    // Slot address from window bit and low index bits.
    always_comb sel_slot = {idx[7], idx[LOW_W-1:0]};

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [3:0] HI = (s >= WIN_DEPTH) ? WIN_HI_HI : WIN_LO_HI;
        localparam logic [7:0] FULL_IDX = {HI, 4'(s % WIN_DEPTH)};
        // One byte register with its own reset value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= win_reset(FULL_IDX);
            else if (we && sel_slot == SLOT_W'(s))
                slot_q[s] <= wdata;
        end
    end

    // Read value and raw exports.
    always_comb begin
        rd_val    = slot_q[sel_slot];
        cache_bit = slot_q[1][4];
        smram_bit = slot_q[4][7];
        arm_bit   = slot_q[WIN_DEPTH][0];
        reg_22    = slot_q[2];
        reg_23    = slot_q[3];
        reg_26    = slot_q[6];
        reg_2d    = slot_q[13];
    end
endmodule

// File: rtl/cfg_pm_ctrl.sv
// Power-management handshake: a trigger write, when armed, produces a
// one-cycle SMI pulse and sets a sticky forced-green flag. A status write
// with bit 0 clear drops the flag.
module cfg_pm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_status,
    input  logic wr_trigger,
    input  logic status_bit0,
    input  logic trigger_bit3,
    input  logic armed,
    output logic forced_green,
    output logic smi_req
);
    logic fire;

    // Armed trigger write.
    always_comb fire = wr_trigger && trigger_bit3 && armed;

    // SMI pulse and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_req      <= 1'b0;
            forced_green <= 1'b0;
        end else begin
            smi_req <= fire;
            if (fire)
                forced_green <= 1'b1;
            else if (wr_status && !status_bit0)
                forced_green <= 1'b0;
        end
    end

    assert_smi_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);
    assert_fire_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_trigger && trigger_bit3 && armed) |=> (smi_req && forced_green));
    assert_green_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !status_bit0) |=> !forced_green);
endmodule

// File: rtl/cfg_index_port.sv
// Top of the indexed configuration port. It holds the index, the gated
// low register and the scratch bytes, and it registers the read data.
// Assumes io_wr and io_rd are never high in the same cycle.
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              in_smm,
    output logic              ext_cache_en,
    output logic              smram_visible,
    output logic              smi_req,
    output logic [7:0]        shadow_ctl_a,
    output logic [7:0]        shadow_blk_en,
    output logic [7:0]        shadow_ctl_b,
    output logic [7:0]        shadow_ext
);
    logic [7:0] idx_q, lowreg_q, scr0_q, scr1_q;
    logic [7:0] win_val, rd_next;
    logic sel_index, sel_lowreg, sel_data, sel_scr0, sel_scr1;
    logic win_we, arm_bit, forced_green;

    cfg_port_decode #(.ADDR_W(ADDR_W)) dec_i (
        .io_addr(io_addr), .idx_q(idx_q),
        .sel_index(sel_index), .sel_lowreg(sel_lowreg), .sel_data(sel_data),
        .sel_scr0(sel_scr0), .sel_scr1(sel_scr1)
    );

    // Data-port write enable, already window-qualified by the decoder.
    always_comb win_we = io_wr && sel_data;

    cfg_win_regs win_i (
        .clk(clk), .rst_n(rst_n), .we(win_we), .idx(idx_q), .wdata(io_wdata),
        .rd_val(win_val), .cache_bit(ext_cache_en), .smram_bit(smram_visible),
        .arm_bit(arm_bit), .reg_22(shadow_ctl_a), .reg_23(shadow_blk_en),
        .reg_26(shadow_ctl_b), .reg_2d(shadow_ext)
    );

    cfg_pm_ctrl pm_i (
        .clk(clk), .rst_n(rst_n),
        .wr_status(win_we && idx_q == IDX_STATUS),
        .wr_trigger(win_we && idx_q == IDX_TRIGGER),
        .status_bit0(io_wdata[0]), .trigger_bit3(io_wdata[3]),
        .armed(arm_bit), .forced_green(forced_green), .smi_req(smi_req)
    );

    // Index, low register and scratch bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= 8'h00;
            lowreg_q <= LOWREG_RESET;
            scr0_q   <= SCR_RESET;
            scr1_q   <= SCR_RESET;
        end else if (io_wr) begin
            if (sel_index)  idx_q    <= io_wdata;
            if (sel_lowreg) lowreg_q <= io_wdata;
            if (sel_scr0)   scr0_q   <= io_wdata;
            if (sel_scr1)   scr1_q   <= io_wdata;
        end
    end

    // Read mux, with the status merge for the status register.
    always_comb begin
        rd_next = 8'hFF;
        if (sel_data) begin
            if (idx_q == IDX_STATUS)
                rd_next = (win_val & 8'hF6) | {4'h0, !in_smm, 2'b00, forced_green};
            else
                rd_next = win_val;
        end else if (sel_lowreg) rd_next = lowreg_q;
        else if (sel_scr0)       rd_next = scr0_q;
        else if (sel_scr1)       rd_next = scr1_q;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     io_rdata <= 8'hFF;
        else if (io_rd) io_rdata <= rd_next;
    end

    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == ADDR_W'(PORT_INDEX)) |=> (idx_q == $past(io_wdata)));
    assert_blocked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == ADDR_W'(PORT_DATA) && idx_q[7:4] != 4'h2
         && idx_q[7:4] != 4'hE) |=> (io_rdata == 8'hFF));
    assert_scratch_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == ADDR_W'(PORT_SCR0)) |=> (scr0_q == $past(io_wdata)));
    assert_cache_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == ADDR_W'(PORT_DATA) && idx_q == 8'h21)
        |=> (ext_cache_en == $past(io_wdata[4])));
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/cfg_index_port_tb.sv
// Bench: a vector table walked by one loop, then directed tests.
module cfg_index_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 31;
    // Row: [47:40] requirement, [39:32] 1=read 0=write, [31:16] addr,
    // [15:8] write data, [7:0] expected read value.
    localparam logic [47:0] VEC [NVEC] = '{
        48'h00_00_0022_21_00,  // index 0x21
        48'h00_00_0024_10_00,  // R2 write
        48'h02_01_0024_00_10,  // R2 read back
        48'h00_00_0022_30_00,  // R3 index outside
        48'h00_00_0024_55_00,  // R3 write blocked
        48'h03_01_0024_00_FF,  // R3 read FF
        48'h00_00_0022_1F_00,  // R3 index just below window
        48'h03_01_0024_00_FF,  // R3 read FF
        48'h00_00_0022_01_00,  // R4 select low reg
        48'h06_01_0023_00_C0,  // R6 low reg reset
        48'h00_00_0023_5A_00,  // R4 write
        48'h04_01_0023_00_5A,  // R4 read back
        48'h00_00_0022_02_00,  // R4 other index
        48'h04_01_0023_00_FF,  // R4 gated read
        48'h00_00_0023_11_00,  // R4 dropped write
        48'h00_00_0022_01_00,
        48'h04_01_0023_00_5A,  // R4 unchanged
        48'h05_01_00E1_00_FF,  // R5 scratch reset
        48'h00_00_00E1_3C_00,  // R5 write scratch 0
        48'h05_01_00E2_00_FF,  // R5 scratch 1 untouched
        48'h05_01_00E1_00_3C,  // R5 scratch 0 read
        48'h01_01_0022_00_FF,  // R1 index port read
        48'h00_00_0022_EF_00,
        48'h06_01_0024_00_40,  // R6 reset of 0xEF
        48'h00_00_0022_2D_00,
        48'h06_01_0024_00_C0,  // R6 reset of 0x2D
        48'h00_00_0050_77_00,  // R11 unmapped write
        48'h0B_01_0050_00_FF,  // R11 unmapped read
        48'h00_00_0022_E5_00,
        48'h00_00_0024_A5_00,  // R2 upper window write
        48'h02_01_0024_00_A5   // R2 upper window read
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic io_wr = 1'b0, io_rd = 1'b0, in_smm = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata, shadow_ctl_a, shadow_blk_en, shadow_ctl_b, shadow_ext;
    logic ext_cache_en, smram_visible, smi_req;
    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_index_port dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .in_smm(in_smm),
        .ext_cache_en(ext_cache_en), .smram_visible(smram_visible), .smi_req(smi_req),
        .shadow_ctl_a(shadow_ctl_a), .shadow_blk_en(shadow_blk_en),
        .shadow_ctl_b(shadow_ctl_b), .shadow_ext(shadow_ext)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        @(posedge clk); @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // Reset state, R6 R7 R8 R11 R12.
        check("R11 rdata reset", io_rdata, 8'hFF);
        check("R7 cache reset", {7'd0, ext_cache_en}, 8'h00);
        check("R7 smram reset", {7'd0, smram_visible}, 8'h00);
        check("R8 smi reset", {7'd0, smi_req}, 8'h00);
        check("R12 reg22 reset", shadow_ctl_a, 8'hC4);
        check("R12 reg23 reset", shadow_blk_en, 8'h00);
        check("R12 reg26 reset", shadow_ctl_b, 8'h10);
        check("R6 reg2D reset", shadow_ext, 8'hC0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][32]) begin
                rd(VEC[i][31:16]);
                check($sformatf("R%0d vector %0d", VEC[i][47:40], i), io_rdata, VEC[i][7:0]);
            end else begin
                wr(VEC[i][31:16], VEC[i][15:8]);
            end
        end

        // R7 side-band outputs.
        wr(16'h0022, 8'h21); wr(16'h0024, 8'h10);
        check("R7 cache on", {7'd0, ext_cache_en}, 8'h01);
        wr(16'h0022, 8'h24); wr(16'h0024, 8'h80);
        check("R7 smram on", {7'd0, smram_visible}, 8'h01);
        // R12 raw export.
        wr(16'h0022, 8'h23); wr(16'h0024, 8'h0F);
        check("R12 reg23 export", shadow_blk_en, 8'h0F);

        // R10 status merge with stored 00.
        wr(16'h0022, 8'hE0);
        in_smm = 1'b0; rd(16'h0024);
        check("R10 not in smm", io_rdata, 8'h08);
        in_smm = 1'b1; rd(16'h0024);
        check("R10 in smm", io_rdata, 8'h00);

        // R8 unarmed trigger raises nothing.
        wr(16'h0022, 8'hE1); wr(16'h0024, 8'h08);
        check("R8 unarmed no smi", {7'd0, smi_req}, 8'h00);
        wr(16'h0022, 8'hE0); rd(16'h0024);
        check("R8 unarmed no green", io_rdata, 8'h00);

        // Arm, then R10 stored bits with bit 3 and 0 overridden.
        wr(16'h0024, 8'hF7);
        in_smm = 1'b0; rd(16'h0024);
        check("R10 merge stored", io_rdata, 8'hFE);

        // R8 armed trigger.
        wr(16'h0022, 8'hE1); wr(16'h0024, 8'h08);
        check("R8 smi pulse high", {7'd0, smi_req}, 8'h01);
        @(negedge clk);
        check("R8 smi pulse one cycle", {7'd0, smi_req}, 8'h00);
        wr(16'h0022, 8'hE0);
        in_smm = 1'b1; rd(16'h0024);
        check("R8 green set", io_rdata, 8'hF7);

        // R9 clear flag.
        wr(16'h0024, 8'hF6); rd(16'h0024);
        check("R9 green cleared", io_rdata, 8'hF6);

        // R11 hold between reads.
        @(negedge clk); io_addr = 16'h00E2;
        repeat (2) @(negedge clk);
        check("R11 rdata hold", io_rdata, 8'hF6);

        finish_run();
    end
endmodule